// File: doc/BRIEF.md
# Calibration EEPROM Programming Sequencer

This block lives on the host side of a display driver link. Given a 6-bit calibration offset and a start pulse, it walks through the complete command-byte script that writes the offset into the driver's on-chip non-volatile cells. The offset is written as two fields: an upper field of two bits and a lower field of four bits. The block then restarts the driver and pulls the stored value back into the driver's working registers. Every byte leaves on a parallel port made of a data byte and a valid flag, and is handed over on a valid/ready handshake.

Between certain bytes the driver needs time: several milliseconds after each program command, and some microseconds after each read command. The sequencer counts these waits in clock cycles. The counts are derived from a clock-frequency parameter and rounded up, and one extra cycle is added so the minimum is always exceeded. A busy flag covers the whole script. A one-cycle done pulse marks its end.

Top module: `cal_burn_seq`

## Requirements
- R1: After reset, cmd_valid, busy and done are all low and no byte is presented until start is seen.
- R2: A start pulse while idle makes busy high on the next cycle, and the first byte handed over is 0xF4 (select command bank 4).
- R3: The 2nd and 3rd bytes are the field loads, upper first: 0x70 | offset[5:4], then 0x60 | offset[3:0]. Both come before any program command (0x52).
- R4: Programming proceeds as 0xA1 (upper select), 0x52, idle-return 0x56, then 0xA0 (lower select), 0x52, 0x56.
- R5: After a 0x52 is accepted, the following 0x56 is not presented for at least PROG_CYC = ceil(CLK_HZ·PROG_WAIT_US/10^6) + 1 clock cycles.
- R6: After both fields are programmed, the sequencer sends 0xF0 (bank 0), then 0x91 (driver reset), then 0xF4 (bank 4 again).
- R7: Read-back proceeds as 0xA1, 0x50, 0x56, 0xA0, 0x50, 0x56. Each 0x56 is held back at least READ_CYC = ceil(CLK_HZ·READ_WAIT_US/10^6) + 1 cycles after its 0x50 is accepted.
- R8: While cmd_valid is high and cmd_ready low, cmd_valid stays high and cmd_byte stays unchanged. A new byte is presented only after the previous one is accepted.
- R9: Exactly 18 bytes are accepted per run. done is high for one cycle only, on the cycle right after the final 0x56 is accepted, and busy is low on that cycle.
- R10: start pulses while busy are ignored. The offset is captured at start, so later changes of the offset input do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins one burn-and-readback run when idle |
| offset | input | 6 | Calibration offset, captured at start |
| cmd_byte | output | 8 | Command byte to the driver |
| cmd_valid | output | 1 | cmd_byte is presented |
| cmd_ready | input | 1 | Driver port takes the byte this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Directed runs use the offset 30 (011110), all-zeros and all-ones, which separate the upper and lower field masks and show whether field bits are dropped or shifted. A mixed pattern, 100101, is also used. Further runs draw random offsets and random ready stall rates, so the byte order and the stable-while-stalled rule are tried under back-pressure as well as with ready held high. Some runs change the offset input and pulse start in mid-run, which separates the captured offset from the live input and shows that a restart is refused. The gap from each accepted program or read command to the following idle-return byte is measured in cycles against the two rounded-up wait counts.

// File: rtl/cal_burn_pkg.sv
package cal_burn_pkg;

    localparam int STEP_N = 18;
    localparam int STEP_W = 5;

    localparam logic [7:0] CMD_BANK4    = 8'hF4;
    localparam logic [7:0] CMD_BANK0    = 8'hF0;
    localparam logic [7:0] CMD_DRV_RST  = 8'h91;
    localparam logic [7:0] CMD_SEL_UP   = 8'hA1;
    localparam logic [7:0] CMD_SEL_LOW  = 8'hA0;
    localparam logic [7:0] CMD_PROG     = 8'h52;
    localparam logic [7:0] CMD_READ     = 8'h50;
    localparam logic [7:0] CMD_IDLE     = 8'h56;
    localparam logic [3:0] LOAD_UP_HI   = 4'h7;
    localparam logic [3:0] LOAD_LOW_HI  = 4'h6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_PROG = 2'd1,
        WK_READ = 2'd2
    } wait_kind_e;

    typedef struct packed {
        seq_state_e          state;
        logic [STEP_W-1:0]   step;
        logic [5:0]          off;
        logic                done;
    } seq_regs_t;

    // Cycles needed to strictly exceed a wait given in microseconds.
    function automatic longint unsigned wait_cycles(input longint unsigned hz,
                                                    input longint unsigned us);
        return (hz * us + 64'd999_999) / 64'd1_000_000 + 64'd1;
    endfunction

    // Command byte issued at each step of the script.
    function automatic logic [7:0] step_byte(input logic [STEP_W-1:0] idx,
                                             input logic [5:0] off);
        logic [7:0] b;
        case (idx)
            5'd0:  b = CMD_BANK4;
            5'd1:  b = {LOAD_UP_HI, 2'b00, off[5:4]};
            5'd2:  b = {LOAD_LOW_HI, off[3:0]};
            5'd3:  b = CMD_SEL_UP;
            5'd4:  b = CMD_PROG;
            5'd5:  b = CMD_IDLE;
            5'd6:  b = CMD_SEL_LOW;
            5'd7:  b = CMD_PROG;
            5'd8:  b = CMD_IDLE;
            5'd9:  b = CMD_BANK0;
            5'd10: b = CMD_DRV_RST;
            5'd11: b = CMD_BANK4;
            5'd12: b = CMD_SEL_UP;
            5'd13: b = CMD_READ;
            5'd14: b = CMD_IDLE;
            5'd15: b = CMD_SEL_LOW;
            5'd16: b = CMD_READ;
            5'd17: b = CMD_IDLE;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    // Wait that follows acceptance of the byte at each step.
    function automatic wait_kind_e step_wait(input logic [STEP_W-1:0] idx);
        wait_kind_e k;
        case (idx)
            5'd4, 5'd7:   k = WK_PROG;
            5'd13, 5'd16: k = WK_READ;
            default:      k = WK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cal_step_rom.sv
module cal_step_rom
    import cal_burn_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    input  logic [5:0]        off,
    output logic [7:0]        cmd,
    output wait_kind_e        wait_kind,
    output logic              last
);

    always_comb begin
        cmd       = step_byte(idx, off);
        wait_kind = step_wait(idx);
        last      = (idx == STEP_W'(STEP_N - 1));
    end

endmodule

// File: rtl/cal_wait_timer.sv
module cal_wait_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cal_burn_seq.sv
module cal_burn_seq
    import cal_burn_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50_000_000,
    parameter int unsigned PROG_WAIT_US = 4000,
    parameter int unsigned READ_WAIT_US = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [5:0] offset,
    output logic [7:0] cmd_byte,
    output logic       cmd_valid,
    input  logic       cmd_ready,
    output logic       busy,
    output logic       done
);

    localparam int unsigned PROG_CYC =
        32'(wait_cycles(64'(CLK_HZ), 64'(PROG_WAIT_US)));
    localparam int unsigned READ_CYC =
        32'(wait_cycles(64'(CLK_HZ), 64'(READ_WAIT_US)));
    localparam int unsigned MAX_CYC  = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC;
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] READ_LOAD = CNT_W'(READ_CYC - 1);

    seq_regs_t          r_d, r_q;
    logic [7:0]         rom_cmd;
    wait_kind_e         rom_wait;
    logic               rom_last;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;

    cal_step_rom u_rom (
        .idx       (r_q.step),
        .off       (r_q.off),
        .cmd       (rom_cmd),
        .wait_kind (rom_wait),
        .last      (rom_last)
    );

    cal_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_SEND;
                    r_d.step  = '0;
                    r_d.off   = offset;
                end
            end
            ST_SEND: begin
                if (cmd_ready) begin
                    if (rom_wait != WK_NONE) begin
                        r_d.state = ST_WAIT;
                        tmr_load  = 1'b1;
                        tmr_val   = (rom_wait == WK_PROG) ? PROG_LOAD : READ_LOAD;
                    end else if (rom_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.step  = r_q.step + STEP_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    r_d.state = ST_SEND;
                    r_d.step  = r_q.step + STEP_W'(1);
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, step: '0, off: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_valid = (r_q.state == ST_SEND);
    assign cmd_byte  = rom_cmd;
    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;

endmodule

// File: rtl/cal_burn_checker.sv
module cal_burn_checker
    import cal_burn_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50_000_000,
    parameter int unsigned PROG_WAIT_US = 4000,
    parameter int unsigned READ_WAIT_US = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] cmd_byte,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       busy,
    input logic       done
);

    localparam int unsigned PROG_CYC =
        32'(wait_cycles(64'(CLK_HZ), 64'(PROG_WAIT_US)));
    localparam int unsigned READ_CYC =
        32'(wait_cycles(64'(CLK_HZ), 64'(READ_WAIT_US)));
    localparam int unsigned MAX_CYC  = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC;
    localparam int          GAP_W    = $clog2(MAX_CYC + 1) + 1;

    wait_kind_e        kind_q;
    logic [GAP_W-1:0]  gap_q;

    // Cycles since the last accepted program or read command.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= WK_NONE;
            gap_q  <= '0;
        end else if (cmd_valid && cmd_ready) begin
            gap_q  <= '0;
            kind_q <= (cmd_byte == CMD_PROG) ? WK_PROG :
                      (cmd_byte == CMD_READ) ? WK_READ : WK_NONE;
        end else if (gap_q < GAP_W'(MAX_CYC)) begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !cmd_valid);

    a_r9_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_ready && cmd_byte == CMD_IDLE));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    a_r1_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    a_r5_prog_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == CMD_IDLE && kind_q == WK_PROG
        |-> gap_q >= GAP_W'(PROG_CYC));

    a_r7_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == CMD_IDLE && kind_q == WK_READ
        |-> gap_q >= GAP_W'(READ_CYC));

endmodule

bind cal_burn_seq cal_burn_checker #(
    .CLK_HZ       (CLK_HZ),
    .PROG_WAIT_US (PROG_WAIT_US),
    .READ_WAIT_US (READ_WAIT_US)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_byte  (cmd_byte),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/cal_burn_seq_bench.sv
module cal_burn_seq_bench;

    // Waits are scaled with a 1 MHz frequency parameter to keep runs short.
    localparam int unsigned HZ   = 1_000_000;
    localparam int unsigned PUS  = 4000;
    localparam int unsigned RUS  = 10;
    localparam int          LIMIT = 150_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] offset = '0;
    logic       cmd_ready = 1'b0;
    logic [7:0] cmd_byte;
    logic       cmd_valid;
    logic       busy;
    logic       done;

    cal_burn_seq #(.CLK_HZ(HZ), .PROG_WAIT_US(PUS), .READ_WAIT_US(RUS)) u_cal_burn_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .offset(offset),
        .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    function automatic int min_wait(input int unsigned hz, input int unsigned us);
        longint unsigned prod = longint'(hz) * longint'(us);
        longint unsigned q = prod / 1_000_000;
        if (q * 1_000_000 != prod) q = q + 1;
        return int'(q) + 1;
    endfunction

    int prog_exp;
    int read_exp;

    function automatic logic [7:0] exp_byte(input int i, input logic [5:0] o);
        logic [7:0] seq [18];
        seq = '{8'hF4, {6'b011100, o[5:4]}, {4'h6, o[3:0]},
                8'hA1, 8'h52, 8'h56, 8'hA0, 8'h52, 8'h56,
                8'hF0, 8'h91, 8'hF4,
                8'hA1, 8'h50, 8'h56, 8'hA0, 8'h50, 8'h56};
        return seq[i];
    endfunction

    function automatic string req_of(input int i);
        if (i == 0) return "R2";
        if (i <= 2) return "R3";
        if (i <= 8) return "R4";
        if (i <= 11) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Ready stall pattern, changed away from the sampling edge.
    int ready_pct = 100;
    always @(posedge clk) begin
        #2;
        cmd_ready <= (int'($urandom % 100) < ready_pct);
    end

    // Output monitor.
    logic [5:0] exp_off = '0;
    int         acc_n = 0;
    int         last_acc_cyc = 0;
    logic [7:0] last_acc_byte = 8'h00;
    bit         prev_valid = 0;
    bit         prev_acc = 0;
    int         gap;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && (!prev_valid || prev_acc) && cmd_byte == 8'h56) begin
                gap = cyc - last_acc_cyc - 1;
                if (last_acc_byte == 8'h52)
                    check(gap >= prog_exp, "R5", "program wait cycles", gap, prog_exp);
                else if (last_acc_byte == 8'h50)
                    check(gap >= read_exp, "R7", "read wait cycles", gap, read_exp);
            end
            if (done) begin
                check(cyc == last_acc_cyc + 1 && last_acc_byte == 8'h56, "R9",
                      "done timing", cyc - last_acc_cyc, 1);
                check(!busy, "R9", "busy at done", busy, 0);
                check(acc_n == 18, "R9", "bytes per run", acc_n, 18);
            end
            prev_acc = 0;
            if (cmd_valid && cmd_ready) begin
                if (acc_n < 18)
                    check(cmd_byte == exp_byte(acc_n, exp_off), req_of(acc_n),
                          $sformatf("byte %0d", acc_n), cmd_byte, exp_byte(acc_n, exp_off));
                else
                    check(0, "R10", "extra byte after run", cmd_byte, 0);
                acc_n++;
                last_acc_cyc = cyc;
                last_acc_byte = cmd_byte;
                prev_acc = 1;
            end
            prev_valid = cmd_valid;
        end
    end

    task automatic run_seq(input logic [5:0] o, input int pct, input bit disturb);
        bit idle_ok;
        ready_pct = pct;
        acc_n = 0;
        @(posedge clk); #2;
        offset = o;
        exp_off = o;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        @(negedge clk);
        check(busy, "R2", "busy after start", busy, 1);
        if (disturb) begin
            // R10: live offset changes and a second start while busy.
            offset = ~o;
            repeat (40) @(posedge clk);
            #2;
            offset = o ^ 6'h15;
            start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        check(!done, "R9", "done pulse width", done, 0);
        idle_ok = 1;
        repeat (20) begin
            @(negedge clk);
            if (cmd_valid || busy) idle_ok = 0;
        end
        check(idle_ok, "R10", "idle after run, no restart", idle_ok, 1);
        check(acc_n == 18, "R10", "no further bytes", acc_n, 18);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        prog_exp = min_wait(HZ, PUS);
        read_exp = min_wait(HZ, RUS);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cmd_valid && !busy && !done, "R1", "outputs in reset",
              {cmd_valid, busy, done}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!cmd_valid && !busy && !done, "R1", "idle after reset",
              {cmd_valid, busy, done}, 0);

        run_seq(6'b011110, 100, 0);
        run_seq(6'b000000, 35, 0);
        run_seq(6'b111111, 60, 1);
        run_seq(6'b100101, 100, 1);
        for (int k = 0; k < 3; k++) begin
            run_seq(6'($urandom), 20 + int'($urandom % 80), bit'(k % 2));
        end

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > LIMIT && !finished) begin
                finished = 1;
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
                summary();
                $finish;
            end
        end
    end

endmodule